// File: doc/BRIEF.md
# Synchronous DRAM Command Front End

This block is the device-side command front end of a synchronous DRAM model, written as synthesizable logic. On every rising clock edge it samples the chip-select, row-strobe, column-strobe and write-enable pins (all active low), the clock-enable pin, a bank select and a multiplexed address. It turns that pin pattern into one of a small set of commands. It keeps an open/idle flag and an open-row register for each bank, and it holds the mode word.

Its outputs are registered. A one-cycle strobe reports each accepted command. Further outputs carry the bank, row and column that the command used, the decoded mode fields, and the clock-enable status (power-down or clock suspend). A later data-path stage uses these outputs. That stage, the storage array and refresh are not part of this block. Misuse, such as opening a bank that is already open or reading from a closed bank, raises an error strobe and leaves all state unchanged.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset, every bank is idle. All command strobes and the error strobe are low, power-down and suspend are low, and the mode word is zero.
- R2: With chip-select high (deselect), the other command pins and the address have no effect. With chip-select low and the row-strobe, column-strobe and write-enable pins all high (NOP), no strobe is raised and no state changes.
- R3: Activate (chip-select and row-strobe low; column-strobe and write-enable high) to an idle bank has three effects in the cycle after the edge: it pulses act_o, it marks that bank open, and it shows the bank on bank_o and the 12-bit row on row_o.
- R4: Read (chip-select and column-strobe low; row-strobe and write-enable high) and write (chip-select, column-strobe and write-enable low; row-strobe high) to an open bank pulse rd_o or wr_o. The 9-bit column from address bits 8..0 appears on col_o, the bank on bank_o, and that bank's open row on row_o.
- R5: Precharge (chip-select, row-strobe and write-enable low; column-strobe high) pulses pre_o. It closes the addressed bank when address bit 10 is low, and every bank when address bit 10 is high.
- R6: Mode set (all four command pins low) while every bank is idle pulses mrs_o and stores {bank bits, address} as the mode word. The decoded fields are: burst length code = address bits 2..0, burst type = bit 3, read latency = bits 6..4, single-write flag = bit 9.
- R7: A mode set while any bank is open is refused. It raises err_o, does not raise mrs_o, and leaves the mode word unchanged.
- R8: An activate to an open bank, or a read or write to an idle bank, raises err_o for one cycle. It raises no command strobe and leaves the bank state unchanged.
- R9: On an edge where clock-enable is sampled low, no command is accepted, every strobe is low in the following cycle, and the bank state and mode word hold.
- R10: If every bank is idle when clock-enable is sampled low, pwr_down_o is high from the next cycle. The first edge with clock-enable high clears it and accepts the command presented at that same edge.
- R11: If any bank is open when clock-enable is sampled low, suspend_o rises instead of pwr_down_o, and it clears on the next edge with clock-enable high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Multiplexed row / column / mode address |
| act_o | output | 1 | Activate accepted |
| rd_o | output | 1 | Read accepted |
| wr_o | output | 1 | Write accepted |
| pre_o | output | 1 | Precharge accepted |
| mrs_o | output | 1 | Mode set accepted |
| err_o | output | 1 | Protocol error |
| bank_o | output | 2 | Bank of last accepted bank command |
| row_o | output | 12 | Row of last activate, or open row of last read/write bank |
| col_o | output | 9 | Column of last read or write |
| bank_open_o | output | 4 | Per-bank open flags |
| burst_len_o | output | 3 | Burst length code |
| burst_type_o | output | 1 | Burst type bit |
| cas_lat_o | output | 3 | Read latency code |
| wr_single_o | output | 1 | Single-location write flag |
| mode_raw_o | output | 14 | Whole stored mode word {bank, address} |
| pwr_down_o | output | 1 | Power-down status |
| suspend_o | output | 1 | Clock suspend status |

## Verification
The hardest case to reach is a command that arrives while clock-enable is low. The pins carry an activate or a mode set that would be legal if it were sampled, yet it must leave no trace. The bench first opens two banks and then drops clock-enable while presenting an activate to a third bank, which brings the block into clock suspend. Later, with every bank closed, it does the same to reach power-down. In both cases it checks that the bank flags and strobes hold. It then raises clock-enable together with a real activate, which proves that the waking edge both clears the status and accepts the command.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   typedef enum logic [2:0] {
      CMD_DESEL,
      CMD_NOP,
      CMD_MRS,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_OTHER
   } sdc_cmd_e;

   localparam int BL_LSB  = 0;
   localparam int BT_BIT  = 3;
   localparam int CL_LSB  = 4;
   localparam int WBS_BIT = 9;

endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
   import sdc_pkg::*;
(
   input  logic      cs_n,
   input  logic      ras_n,
   input  logic      cas_n,
   input  logic      we_n,
   output sdc_cmd_e  cmd
);
   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b000:  cmd = CMD_MRS;
            3'b010:  cmd = CMD_PRE;
            3'b011:  cmd = CMD_ACT;
            3'b100:  cmd = CMD_WR;
            3'b101:  cmd = CMD_RD;
            3'b111:  cmd = CMD_NOP;
            default: cmd = CMD_OTHER;
         endcase
      end
   end
endmodule

// File: rtl/sdc_bank_table.sv
module sdc_bank_table #(
   parameter int BANKS = 4,
   parameter int BA_W  = 2,
   parameter int ROW_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_en,
   input  logic              close_en,
   input  logic              close_all,
   input  logic [BA_W-1:0]   bank_sel,
   input  logic [ROW_W-1:0]  row_in,
   output logic [BANKS-1:0]  open_vec,
   output logic [ROW_W-1:0]  sel_row
);
   logic [ROW_W-1:0] row_arr [BANKS];

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_bank
         logic             open_q;
         logic [ROW_W-1:0] row_q;
         logic             hit;

         assign hit = (bank_sel == BA_W'(b));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               open_q <= 1'b0;
               row_q  <= '0;
            end else if (open_en && hit) begin
               open_q <= 1'b1;
               row_q  <= row_in;
            end else if (close_en && (close_all || hit)) begin
               open_q <= 1'b0;
            end
         end

         assign open_vec[b] = open_q;
         assign row_arr[b]  = row_q;
      end
   endgenerate

   assign sel_row = row_arr[bank_sel];
endmodule

// File: rtl/sdc_mode_reg.sv
module sdc_mode_reg
   import sdc_pkg::*;
#(
   parameter int MODE_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] din,
   output logic [MODE_W-1:0] raw,
   output logic [2:0]        burst_len,
   output logic              burst_type,
   output logic [2:0]        cas_lat,
   output logic              wr_single
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     raw <= '0;
      else if (wr_en) raw <= din;
   end

   assign burst_len  = raw[BL_LSB +: 3];
   assign burst_type = raw[BT_BIT];
   assign cas_lat    = raw[CL_LSB +: 3];
   assign wr_single  = raw[WBS_BIT];
endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
   import sdc_pkg::*;
#(
   parameter int BA_W   = 2,
   parameter int ADDR_W = 12,
   parameter int ROW_W  = 12,
   parameter int COL_W  = 9,
   parameter int AP_BIT = 10,
   localparam int BANKS  = 1 << BA_W,
   localparam int MODE_W = ADDR_W + BA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              cs_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [BA_W-1:0]   ba,
   input  logic [ADDR_W-1:0] addr,
   output logic              act_o,
   output logic              rd_o,
   output logic              wr_o,
   output logic              pre_o,
   output logic              mrs_o,
   output logic              err_o,
   output logic [BA_W-1:0]   bank_o,
   output logic [ROW_W-1:0]  row_o,
   output logic [COL_W-1:0]  col_o,
   output logic [BANKS-1:0]  bank_open_o,
   output logic [2:0]        burst_len_o,
   output logic              burst_type_o,
   output logic [2:0]        cas_lat_o,
   output logic              wr_single_o,
   output logic [MODE_W-1:0] mode_raw_o,
   output logic              pwr_down_o,
   output logic              suspend_o
);
   initial begin
      assert (ROW_W <= ADDR_W) else $error("ROW_W exceeds ADDR_W");
      assert (COL_W <= ADDR_W) else $error("COL_W exceeds ADDR_W");
      assert (AP_BIT < ADDR_W && AP_BIT >= COL_W) else $error("AP_BIT out of range");
      assert (ADDR_W > WBS_BIT) else $error("ADDR_W too small for mode fields");
   end

   sdc_cmd_e         cmd;
   logic [BANKS-1:0] open_vec;
   logic [ROW_W-1:0] sel_row;
   logic             all_idle, tgt_open;
   logic             act_ok, act_bad, rd_ok, wr_ok, rdwr_bad;
   logic             mrs_ok, mrs_bad, pre_go;

   sdc_decode u_dec (
      .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .cmd (cmd)
   );

   assign all_idle = (open_vec == '0);
   assign tgt_open = open_vec[ba];

   always_comb begin
      act_ok   = cke && cmd == CMD_ACT && !tgt_open;
      act_bad  = cke && cmd == CMD_ACT &&  tgt_open;
      rd_ok    = cke && cmd == CMD_RD  &&  tgt_open;
      wr_ok    = cke && cmd == CMD_WR  &&  tgt_open;
      rdwr_bad = cke && (cmd == CMD_RD || cmd == CMD_WR) && !tgt_open;
      mrs_ok   = cke && cmd == CMD_MRS &&  all_idle;
      mrs_bad  = cke && cmd == CMD_MRS && !all_idle;
      pre_go   = cke && cmd == CMD_PRE;
   end

   sdc_bank_table #(.BANKS(BANKS), .BA_W(BA_W), .ROW_W(ROW_W)) u_banks (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_en   (act_ok),
      .close_en  (pre_go),
      .close_all (addr[AP_BIT]),
      .bank_sel  (ba),
      .row_in    (addr[ROW_W-1:0]),
      .open_vec  (open_vec),
      .sel_row   (sel_row)
   );

   sdc_mode_reg #(.MODE_W(MODE_W)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (mrs_ok),
      .din        ({ba, addr}),
      .raw        (mode_raw_o),
      .burst_len  (burst_len_o),
      .burst_type (burst_type_o),
      .cas_lat    (cas_lat_o),
      .wr_single  (wr_single_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_o      <= 1'b0;
         rd_o       <= 1'b0;
         wr_o       <= 1'b0;
         pre_o      <= 1'b0;
         mrs_o      <= 1'b0;
         err_o      <= 1'b0;
         bank_o     <= '0;
         row_o      <= '0;
         col_o      <= '0;
         pwr_down_o <= 1'b0;
         suspend_o  <= 1'b0;
      end else begin
         act_o      <= act_ok;
         rd_o       <= rd_ok;
         wr_o       <= wr_ok;
         pre_o      <= pre_go;
         mrs_o      <= mrs_ok;
         err_o      <= act_bad || rdwr_bad || mrs_bad;
         pwr_down_o <= !cke &&  all_idle;
         suspend_o  <= !cke && !all_idle;
         if (act_ok) begin
            bank_o <= ba;
            row_o  <= addr[ROW_W-1:0];
         end else if (rd_ok || wr_ok) begin
            bank_o <= ba;
            row_o  <= sel_row;
            col_o  <= addr[COL_W-1:0];
         end else if (pre_go) begin
            bank_o <= ba;
         end
      end
   end

   assign bank_open_o = open_vec;
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
   parameter int BA_W   = 2,
   parameter int ADDR_W = 12,
   parameter int AP_BIT = 10,
   localparam int BANKS  = 1 << BA_W,
   localparam int MODE_W = ADDR_W + BA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              cs_n,
   input logic [ADDR_W-1:0] addr,
   input logic              act_o,
   input logic              rd_o,
   input logic              wr_o,
   input logic              pre_o,
   input logic              mrs_o,
   input logic              err_o,
   input logic [BA_W-1:0]   bank_o,
   input logic [BANKS-1:0]  bank_open_o,
   input logic [MODE_W-1:0] mode_raw_o,
   input logic              pwr_down_o,
   input logic              suspend_o
);
   logic any_strobe;
   assign any_strobe = act_o | rd_o | wr_o | pre_o | mrs_o | err_o;

   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act_o, rd_o, wr_o, pre_o, mrs_o, err_o}));

   p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && cke) |=> !any_strobe);

   p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act_o |-> bank_open_o[bank_o]);

   p_rdwr_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_o || wr_o) |-> bank_open_o[bank_o]);

   p_pre_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_o && $past(addr[AP_BIT])) |-> (bank_open_o == '0));

   p_mrs_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_o |-> ($past(bank_open_o) == '0));

   p_cke_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> (!any_strobe && $stable(bank_open_o) && $stable(mode_raw_o)));

   p_pd_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke && bank_open_o == '0) |=> pwr_down_o);

   p_pd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down_o |-> (bank_open_o == '0));

   p_pd_susp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_down_o && suspend_o));
endmodule

bind sdram_cmd_front sdc_checker #(.BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cke         (cke),
   .cs_n        (cs_n),
   .addr        (addr),
   .act_o       (act_o),
   .rd_o        (rd_o),
   .wr_o        (wr_o),
   .pre_o       (pre_o),
   .mrs_o       (mrs_o),
   .err_o       (err_o),
   .bank_o      (bank_o),
   .bank_open_o (bank_open_o),
   .mode_raw_o  (mode_raw_o),
   .pwr_down_o  (pwr_down_o),
   .suspend_o   (suspend_o)
);

// File: tb/tb_sdram_cmd_front.sv
module tb_sdram_cmd_front;
   localparam int CLK_P = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic act_o, rd_o, wr_o, pre_o, mrs_o, err_o;
   logic [1:0]  bank_o;
   logic [11:0] row_o;
   logic [8:0]  col_o;
   logic [3:0]  bank_open_o;
   logic [2:0]  burst_len_o, cas_lat_o;
   logic        burst_type_o, wr_single_o;
   logic [13:0] mode_raw_o;
   logic        pwr_down_o, suspend_o;

   int n_run = 0, n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   sdram_cmd_front dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .mrs_o(mrs_o),
      .err_o(err_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
      .bank_open_o(bank_open_o), .burst_len_o(burst_len_o),
      .burst_type_o(burst_type_o), .cas_lat_o(cas_lat_o),
      .wr_single_o(wr_single_o), .mode_raw_o(mode_raw_o),
      .pwr_down_o(pwr_down_o), .suspend_o(suspend_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // pins {cs_n,ras_n,cas_n,we_n}; applied at negedge, result sampled after the next posedge
   task automatic issue(input logic k, input logic [3:0] pins, input logic [1:0] b, input logic [11:0] a);
      @(negedge clk);
      cke = k; {cs_n, ras_n, cas_n, we_n} = pins; ba = b; addr = a;
      @(posedge clk);
      #1;
   endtask

   localparam logic [3:0] P_DES = 4'b1000, P_NOP = 4'b0111, P_MRS = 4'b0000,
                          P_ACT = 4'b0011, P_RD  = 4'b0101, P_WR  = 4'b0100,
                          P_PRE = 4'b0010;

   function automatic logic [5:0] strobes();
      return {act_o, rd_o, wr_o, pre_o, mrs_o, err_o};
   endfunction

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R1 banks idle", 32'(bank_open_o), 0);
      chk("R1 strobes", 32'(strobes()), 0);
      chk("R1 pd/susp", 32'({pwr_down_o, suspend_o}), 0);
      chk("R1 mode", 32'(mode_raw_o), 0);
   endtask

   task automatic t_mode_idle();
      issue(1, P_MRS, 2'd2, 12'h232);
      chk("R6 mrs strobe", 32'(strobes()), 32'b000010);
      chk("R6 raw", 32'(mode_raw_o), 32'h2232);
      chk("R6 burst len", 32'(burst_len_o), 2);
      chk("R6 burst type", 32'(burst_type_o), 0);
      chk("R6 latency", 32'(cas_lat_o), 3);
      chk("R6 single write", 32'(wr_single_o), 1);
   endtask

   task automatic t_quiet();
      issue(1, P_DES | 4'b0011, 2'd1, 12'h0AA); // cs high, activate pattern below
      chk("R2 deselect strobes", 32'(strobes()), 0);
      chk("R2 deselect banks", 32'(bank_open_o), 0);
      issue(1, P_NOP, 2'd0, 12'hFFF);
      chk("R2 nop strobes", 32'(strobes()), 0);
      chk("R2 nop mode held", 32'(mode_raw_o), 32'h2232);
   endtask

   task automatic t_open_rw();
      issue(1, P_ACT, 2'd1, 12'hABC);
      chk("R3 act strobe", 32'(act_o), 1);
      chk("R3 bank", 32'(bank_o), 1);
      chk("R3 row", 32'(row_o), 32'hABC);
      chk("R3 open", 32'(bank_open_o), 32'b0010);
      issue(1, P_ACT, 2'd3, 12'h123);
      chk("R3 open two", 32'(bank_open_o), 32'b1010);
      issue(1, P_RD, 2'd1, 12'hDF5);
      chk("R4 rd strobe", 32'(strobes()), 32'b010000);
      chk("R4 rd col", 32'(col_o), 32'h1F5);
      chk("R4 rd row", 32'(row_o), 32'hABC);
      issue(1, P_WR, 2'd3, 12'h00A);
      chk("R4 wr strobe", 32'(strobes()), 32'b001000);
      chk("R4 wr bank", 32'(bank_o), 3);
      chk("R4 wr row", 32'(row_o), 32'h123);
      chk("R4 wr col", 32'(col_o), 32'h00A);
   endtask

   task automatic t_errors();
      issue(1, P_ACT, 2'd1, 12'h777);
      chk("R8 act open err", 32'(strobes()), 32'b000001);
      chk("R8 banks kept", 32'(bank_open_o), 32'b1010);
      issue(1, P_RD, 2'd0, 12'h010);
      chk("R8 rd idle err", 32'(strobes()), 32'b000001);
      chk("R8 col kept", 32'(col_o), 32'h00A);
      issue(1, P_NOP, 2'd0, 12'h000);
      chk("R8 err one cycle", 32'(err_o), 0);
      issue(1, P_MRS, 2'd0, 12'h070);
      chk("R7 mrs refused", 32'(strobes()), 32'b000001);
      chk("R7 mode kept", 32'(mode_raw_o), 32'h2232);
   endtask

   task automatic t_suspend();
      issue(0, P_ACT, 2'd0, 12'h456);
      chk("R9 no act in suspend", 32'(strobes()), 0);
      chk("R9 banks held", 32'(bank_open_o), 32'b1010);
      chk("R11 suspend", 32'({pwr_down_o, suspend_o}), 32'b01);
      issue(0, P_PRE, 2'd1, 12'h400);
      chk("R9 pre ignored", 32'(bank_open_o), 32'b1010);
      issue(1, P_NOP, 2'd0, 12'h000);
      chk("R11 suspend cleared", 32'(suspend_o), 0);
   endtask

   task automatic t_precharge();
      issue(1, P_PRE, 2'd1, 12'h000);
      chk("R5 pre strobe", 32'(pre_o), 1);
      chk("R5 single close", 32'(bank_open_o), 32'b1000);
      issue(1, P_ACT, 2'd0, 12'h001);
      issue(1, P_PRE, 2'd2, 12'h400);
      chk("R5 close all", 32'(bank_open_o), 0);
   endtask

   task automatic t_powerdown();
      issue(0, P_NOP, 2'd0, 12'h000);
      chk("R10 pd entered", 32'({pwr_down_o, suspend_o}), 32'b10);
      issue(0, P_MRS, 2'd1, 12'h005);
      chk("R9 mrs ignored", 32'(mode_raw_o), 32'h2232);
      chk("R10 pd held", 32'(pwr_down_o), 1);
      issue(1, P_ACT, 2'd2, 12'h055);
      chk("R10 pd exit", 32'(pwr_down_o), 0);
      chk("R10 wake cmd", 32'(act_o), 1);
      chk("R10 wake bank", 32'(bank_open_o), 32'b0100);
      issue(1, P_PRE, 2'd0, 12'h400);
      chk("R5 final close", 32'(bank_open_o), 0);
   endtask

   initial begin
      #(CLK_P * 20000);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_mode_idle();
      t_quiet();
      t_open_rw();
      t_errors();
      t_suspend();
      t_precharge();
      t_powerdown();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule